// File: doc/BRIEF.md
# Receive Byte Queue with Threshold Match

This block is the receive-side byte queue of a serial bus controller. The bus receiver pushes each incoming byte into a queue of up to sixteen entries. The host pops bytes out in arrival order. The host can read the current fill level and can program a threshold level. Both values are 4-bit codes that count entries minus one.

While the queue holds exactly the programmed number of entries, the block drives a throttle output. The upstream receiver uses this output to stop taking bytes from the transmitter. In the same condition, the block raises a receive interrupt. A host pop clears the interrupt. The interrupt comes back only when the level and the threshold become equal again, either through later traffic or through a threshold write. Because of the minus-one code, an empty queue and a queue with one byte both read as 0. A separate empty flag tells the two apart, and an empty queue never counts as a match. Writes into a full queue and reads from an empty queue are refused, and each sets its own sticky flag. Only a synchronous reset clears these flags.

Top module: `rxq_thresh_fifo`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge) the outputs are: `fifo_empty`=1, `fifo_full`=0, `occ_value`=0, `thr_value`=0, `rx_irq`=0, `rx_throttle`=0, `ovf_flag`=0, `unf_flag`=0, `host_rd_data`=0.
- R2: Bytes leave in the order they were accepted. A pop presents its byte on `host_rd_data` starting the cycle after the `host_rd_en` edge, and the value holds until the next pop.
- R3: `occ_value` equals the entry count minus one, or 0 when the queue is empty. For example, 4'b1001 means ten entries. `fifo_empty` is high at zero entries and `fifo_full` is high at DEPTH (16) entries.
- R4: A cycle with `thr_wr_en` high loads `thr_wdata` into the threshold. The threshold reads back on `thr_value` from the next cycle, in the same minus-one code.
- R5: `rx_throttle` is high exactly while the queue is non-empty and `occ_value` equals `thr_value`. Both values are taken from registers.
- R6: `rx_irq` rises in the cycle the equality is newly reached through a write or a threshold write. It then stays high for as long as the equality holds and no pop occurs. `rx_irq` high implies `rx_throttle` high.
- R7: An accepted pop forces `rx_irq` low in the next cycle, and this takes priority over any new equality. While the equality continues, `rx_irq` stays low until the equality is first lost and then reached again. Rewriting the threshold to the value it already holds does not re-arm it.
- R8: A write while `fifo_full` is high is dropped, even if a pop happens in the same cycle. The dropped write sets `ovf_flag`, which stays high until reset.
- R9: A read while `fifo_empty` is high leaves `host_rd_data` and the count unchanged. It sets `unf_flag`, which stays high until reset.
- R10: A cycle in which a write and a read are both accepted leaves the occupancy unchanged.
- R11: An empty queue never signals a match. `rx_throttle` and `rx_irq` stay low at zero entries even when the threshold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_wr_en | input | 1 | Push request from the bus receiver |
| rx_wr_data | input | 8 | Byte to push |
| host_rd_en | input | 1 | Pop request from the host |
| host_rd_data | output | 8 | Most recently popped byte |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_data | input | 4 | New threshold code (entries minus one) |
| thr_value | output | 4 | Current threshold code |
| occ_value | output | 4 | Fill level code (entries minus one) |
| fifo_empty | output | 1 | Queue holds no entries |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| rx_irq | output | 1 | Receive threshold interrupt |
| rx_throttle | output | 1 | Hold-off to the upstream receiver |
| ovf_flag | output | 1 | Sticky: write refused while full |
| unf_flag | output | 1 | Sticky: read refused while empty |

## Verification
Random traffic alternates between fill-heavy and drain-heavy phases, so the level sweeps from empty to full and back with threshold writes scattered through it. This checks the equality, the interrupt arming and the data order at every level. Directed sequences separate the cases that the minus-one code and the arming rule could confuse: one entry versus none with a threshold of 0, a balanced push and pop that holds the level at the threshold with the interrupt disarmed, a repeated threshold write versus a changed-then-restored one, and pushes into a full queue and pops from an empty one.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // fill-level code: entries minus one, floor at zero
  function automatic int occ_code(int entries);
    return (entries == 0) ? 0 : entries - 1;
  endfunction

  // equality of the level with the threshold code; an empty queue never matches
  function automatic logic level_match(int entries, int thr_code);
    return (entries != 0) && (occ_code(entries) == thr_code);
  endfunction

  // circular pointer advance
  function automatic int ptr_next(int ptr, int depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction

  // next entry count from accepted push/pop
  function automatic int count_next(int entries, logic push, logic pop);
    return entries + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      rdata  <= '0;
    end else begin
      if (push) wr_ptr <= AW'(rxq_pkg::ptr_next(int'(wr_ptr), DEPTH));
      if (pop) begin
        rdata  <= mem[rd_ptr];
        rd_ptr <= AW'(rxq_pkg::ptr_next(int'(rd_ptr), DEPTH));
      end
    end
  end

  // R2: popped data holds until the next pop
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !pop |=> $stable(rdata));

endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_req,
  input  logic                         rd_req,
  output logic                         push,
  output logic                         pop,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic [$clog2(DEPTH+1)-1:0]   count_nxt,
  output logic [$clog2(DEPTH)-1:0]     occ,
  output logic                         empty,
  output logic                         full,
  output logic                         ovf,
  output logic                         unf
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int OW = $clog2(DEPTH);

  logic wr_refused;
  logic rd_refused;

  assign empty      = (count == '0);
  assign full       = (count == CW'(DEPTH));
  assign push       = wr_req && !full;
  assign pop        = rd_req && !empty;
  assign wr_refused = wr_req && full;
  assign rd_refused = rd_req && empty;
  assign count_nxt  = CW'(rxq_pkg::count_next(int'(count), push, pop));
  assign occ        = OW'(rxq_pkg::occ_code(int'(count)));

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      count <= count_nxt;
      if (wr_refused) ovf <= 1'b1;
      if (rd_refused) unf <= 1'b1;
    end
  end

  // R3: level never exceeds the depth
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R8: refused write leaves the queue full and the flag set
  p_full_write_dropped_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full && !rd_req) |=> (full && ovf));

  // R8: overflow flag is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R9: refused read leaves the level and sets the flag
  p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty && !wr_req) |=> (empty && unf));

  // R10: balanced traffic keeps the level
  p_balanced_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_req && rd_req && !empty && !full) |=> $stable(count));

endmodule

// File: rtl/rxq_match.sv
module rxq_match #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic [$clog2(DEPTH+1)-1:0] count_nxt,
  input  logic                       pop,
  input  logic                       empty,
  input  logic                       thr_we,
  input  logic [$clog2(DEPTH)-1:0]   thr_wdata,
  output logic [$clog2(DEPTH)-1:0]   thr,
  output logic                       throttle,
  output logic                       irq
);
  localparam int OW = $clog2(DEPTH);

  logic [OW-1:0] thr_d;
  logic          match_now;
  logic          match_nxt;
  logic          match_fresh;
  logic          irq_d;

  assign thr_d       = thr_we ? thr_wdata : thr;
  assign match_now   = rxq_pkg::level_match(int'(count), int'(thr));
  assign match_nxt   = rxq_pkg::level_match(int'(count_nxt), int'(thr_d));
  assign match_fresh = match_nxt && !match_now;
  assign throttle    = match_now;

  always_comb begin
    if (pop)              irq_d = 1'b0;
    else if (match_fresh) irq_d = 1'b1;
    else if (match_nxt)   irq_d = irq;
    else                  irq_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr <= '0;
      irq <= 1'b0;
    end else begin
      thr <= thr_d;
      irq <= irq_d;
    end
  end

  // R4: threshold write lands in the next cycle
  p_thr_write_r4: assert property (@(posedge clk) disable iff (rst)
    thr_we |=> (thr == $past(thr_wdata)));

  // R6: interrupt only with the equality present
  p_irq_needs_match_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> throttle);

  // R7: a pop clears the interrupt
  p_pop_clears_irq_r7: assert property (@(posedge clk) disable iff (rst)
    pop |=> !irq);

  // R11: an empty queue never matches
  p_empty_no_match_r11: assert property (@(posedge clk) disable iff (rst)
    empty |-> (!throttle && !irq));

endmodule

// File: rtl/rxq_thresh_fifo.sv
module rxq_thresh_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rx_wr_en,
  input  logic [DATA_W-1:0]        rx_wr_data,
  input  logic                     host_rd_en,
  output logic [DATA_W-1:0]        host_rd_data,
  input  logic                     thr_wr_en,
  input  logic [$clog2(DEPTH)-1:0] thr_wr_data,
  output logic [$clog2(DEPTH)-1:0] thr_value,
  output logic [$clog2(DEPTH)-1:0] occ_value,
  output logic                     fifo_empty,
  output logic                     fifo_full,
  output logic                     rx_irq,
  output logic                     rx_throttle,
  output logic                     ovf_flag,
  output logic                     unf_flag
);
  localparam int CW = $clog2(DEPTH+1);

  logic          push_ok;
  logic          pop_ok;
  logic [CW-1:0] lvl_count;
  logic [CW-1:0] lvl_count_nxt;

  rxq_level #(.DEPTH(DEPTH)) level_i (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (rx_wr_en),
    .rd_req    (host_rd_en),
    .push      (push_ok),
    .pop       (pop_ok),
    .count     (lvl_count),
    .count_nxt (lvl_count_nxt),
    .occ       (occ_value),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .ovf       (ovf_flag),
    .unf       (unf_flag)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk   (clk),
    .rst   (rst),
    .push  (push_ok),
    .pop   (pop_ok),
    .wdata (rx_wr_data),
    .rdata (host_rd_data)
  );

  rxq_match #(.DEPTH(DEPTH)) match_i (
    .clk       (clk),
    .rst       (rst),
    .count     (lvl_count),
    .count_nxt (lvl_count_nxt),
    .pop       (pop_ok),
    .empty     (fifo_empty),
    .thr_we    (thr_wr_en),
    .thr_wdata (thr_wr_data),
    .thr       (thr_value),
    .throttle  (rx_throttle),
    .irq       (rx_irq)
  );

  // R5: throttle tracks the registered equality at the ports
  p_throttle_equal_r5: assert property (@(posedge clk) disable iff (rst)
    rx_throttle |-> (!fifo_empty && occ_value == thr_value));

endmodule

// File: tb/rxq_thresh_fifo_tb_top.sv
`timescale 1ns/1ps
module rxq_thresh_fifo_tb_top;
  localparam int DEPTH = 16;
  localparam longint WD_NS = 64'd3_000_000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       t_we = 1'b0;
  logic [3:0] t_wd = '0;
  logic [3:0] t_val, occ;
  logic       empty, full, irq, throttle, ovf, unf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  logic [7:0] q [DEPTH];
  int head = 0, cnt = 0, m_thr = 0;
  bit m_irq = 0, m_ovf = 0, m_unf = 0;
  int m_last = 0;

  always #10 clk = ~clk;

  rxq_thresh_fifo dut_i (
    .clk(clk), .rst(rst),
    .rx_wr_en(wr_en), .rx_wr_data(wr_data),
    .host_rd_en(rd_en), .host_rd_data(rd_data),
    .thr_wr_en(t_we), .thr_wr_data(t_wd), .thr_value(t_val),
    .occ_value(occ), .fifo_empty(empty), .fifo_full(full),
    .rx_irq(irq), .rx_throttle(throttle),
    .ovf_flag(ovf), .unf_flag(unf)
  );

  function automatic bit eq_level(int n, int t);
    return (n > 0) && (n == t + 1);
  endfunction

  function automatic int exp_occ(int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R3", "occupancy", int'(occ), exp_occ(cnt));
    chk("R3", "empty", int'(empty), int'(cnt == 0));
    chk("R3", "full", int'(full), int'(cnt == DEPTH));
    chk("R4", "threshold", int'(t_val), m_thr);
    chk("R5", "throttle", int'(throttle), int'(eq_level(cnt, m_thr)));
    chk("R6", "irq", int'(irq), int'(m_irq));
    chk("R2", "read data", int'(rd_data), m_last);
    chk("R8", "overflow", int'(ovf), int'(m_ovf));
    chk("R9", "underflow", int'(unf), int'(m_unf));
  endtask

  // one clock of stimulus, model update, compare
  task automatic step(bit w, logic [7:0] wd, bit r, bit tw, logic [3:0] twd);
    bit push, pop, old_m, new_m;
    wr_en = w; wr_data = wd; rd_en = r; t_we = tw; t_wd = twd;
    @(posedge clk); #1;
    push  = w && (cnt < DEPTH);
    pop   = r && (cnt > 0);
    old_m = eq_level(cnt, m_thr);
    if (w && !push) m_ovf = 1;
    if (r && !pop)  m_unf = 1;
    if (push) q[(head + cnt) % DEPTH] = wd;
    if (pop) begin
      m_last = int'(q[head]);
      head = (head + 1) % DEPTH;
    end
    cnt = cnt + int'(push) - int'(pop);
    if (tw) m_thr = int'(twd);
    new_m = eq_level(cnt, m_thr);
    if (pop) m_irq = 0;
    else if (new_m && !old_m) m_irq = 1;
    else if (!new_m) m_irq = 0;
    wr_en = 0; rd_en = 0; t_we = 0;
    check_all();
  endtask

  task automatic do_reset();
    rst = 1; wr_en = 0; rd_en = 0; t_we = 0;
    repeat (3) @(posedge clk);
    #1; rst = 0;
    head = 0; cnt = 0; m_thr = 0; m_irq = 0; m_ovf = 0; m_unf = 0; m_last = 0;
  endtask

  initial begin
    #(WD_NS);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R1 reset values
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "full", int'(full), 0);
    chk("R1", "occ", int'(occ), 0);
    chk("R1", "thr", int'(t_val), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "throttle", int'(throttle), 0);
    chk("R1", "ovf", int'(ovf), 0);
    chk("R1", "unf", int'(unf), 0);
    chk("R1", "rdata", int'(rd_data), 0);

    // R11: empty with threshold 0 does not match; one entry does
    step(0, 8'h00, 0, 0, 4'd0);
    chk("R11", "throttle empty", int'(throttle), 0);
    chk("R11", "irq empty", int'(irq), 0);
    step(1, 8'hA5, 0, 0, 4'd0);
    chk("R11", "one entry throttle", int'(throttle), 1);
    chk("R6", "one entry irq", int'(irq), 1);
    step(0, 8'h00, 1, 0, 4'd0);
    chk("R2", "first byte", int'(rd_data), 'hA5);
    chk("R7", "irq after pop", int'(irq), 0);

    // R10/R7: balanced traffic at the threshold keeps irq disarmed
    step(0, 8'h00, 0, 1, 4'd2);
    for (int i = 0; i < 3; i++) step(1, 8'(8'h10 + i), 0, 0, 4'd2);
    chk("R6", "irq at three", int'(irq), 1);
    step(1, 8'h20, 1, 0, 4'd2);
    chk("R10", "occ kept", int'(occ), 2);
    chk("R7", "irq disarmed", int'(irq), 0);
    chk("R5", "throttle kept", int'(throttle), 1);
    step(0, 8'h00, 0, 1, 4'd2);
    chk("R7", "same thr no rearm", int'(irq), 0);
    step(0, 8'h00, 0, 1, 4'd5);
    step(0, 8'h00, 0, 1, 4'd2);
    chk("R7", "thr rearm", int'(irq), 1);

    // R8: fill past full, including write with pop while full
    for (int i = 0; i < DEPTH + 2; i++) step(1, 8'(8'h40 + i), 0, 0, 4'd0);
    chk("R8", "full", int'(full), 1);
    chk("R8", "ovf", int'(ovf), 1);
    step(1, 8'hEE, 1, 0, 4'd0);
    chk("R8", "full write with pop", int'(occ), DEPTH - 2);

    // R9: drain past empty
    for (int i = 0; i < DEPTH + 2; i++) step(0, 8'h00, 1, 0, 4'd0);
    chk("R9", "unf", int'(unf), 1);
    chk("R9", "empty", int'(empty), 1);

    // random phases
    do_reset();
    for (int i = 0; i < 6000; i++) begin
      int pw = ((i / 400) % 2 == 0) ? 70 : 30;
      bit w = ($urandom % 100) < pw;
      bit r = ($urandom % 100) < (100 - pw);
      bit tw = ($urandom % 25) == 0;
      step(w, 8'($urandom), r, tw, 4'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule